// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a bus slave on a two-wire I2C-compatible bus. It lets an external master write and read a small register file that sits beside it in the chip. SCL and SDA come in from open-drain pads and are sampled on the system clock. The block drives SDA only through a pull-down enable. The register file is outside the block. The slave gives it a register address, write data and a one-cycle write strobe, and takes back read data for the addressed register.

A write transaction has three bytes: the chip address with the direction bit at 0, a register pointer, and one data byte. A read is a pointer write followed by a repeated START that carries the chip address with the direction bit at 1. The slave then returns the pointed register until the master declines a byte. A supply-undervoltage input silences the slave on the bus at once, even in the middle of a byte. While it is asserted the slave sends no acknowledge and no read data.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset, sdaPullDown is 0, regWrEn is 0 and regAddr is 0.
- R2: The first byte after a START is a 7-bit chip address (parameter, default 0x60), most significant bit first, followed by a direction bit (0 = write, 1 = read). On a match the slave holds SDA low through the ninth SCL pulse.
- R3: On an address mismatch the slave acknowledges nothing, drives nothing and writes nothing until the next START.
- R4: In a write, the second byte is latched as the register pointer and appears on regAddr. The third byte appears on regWrData with a regWrEn pulse exactly one clock long. Both bytes are acknowledged.
- R5: Data bytes beyond the first in a write transaction are not acknowledged and cause no write.
- R6: After a pointer write, a repeated START and a read address, the slave shifts out the pointed register, most significant bit first, on the eight SCL pulses after its acknowledge.
- R7: If the master acknowledges (SDA low on the ninth pulse), the same register is sent again. If it does not, the slave releases SDA and drives nothing on later pulses.
- R8: While uvloIn is 1, sdaPullDown is 0 on every cycle. Decoding continues, so a write issued under undervoltage still reaches the register file.
- R9: A START or STOP at any point abandons the byte in progress without a write. STOP returns the slave to idle; START returns it to address reception.
- R10: sdaPullDown only becomes active while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level sampled from the pad |
| sdaIn | input | 1 | SDA level sampled from the pad |
| uvloIn | input | 1 | Supply undervoltage; 1 blocks all SDA driving |
| sdaPullDown | output | 1 | 1 pulls the SDA pad low |
| regAddr | output | ADDR_W (8) | Register pointer presented to the register file |
| regWrData | output | 8 | Data byte to be written |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 8 | Contents of the register at regAddr |

## Verification
The assertions check the cycle-level rules on every cycle. The pad is never pulled low while undervoltage is asserted. A new pull-down only starts with SCL low. The write strobe never lasts two cycles. A START always leads to address reception and a STOP to idle. The ignoring state never acknowledges, loads read data or writes. Only the bench's transactions can show what the bytes mean. They confirm that acknowledges land on the ninth pulse, that a wrong address leaves the registers untouched, and that read data comes back bit-exact through a repeated START. They also cover repeated reads on a master acknowledge, the release after a NACK, the loss of a byte cut short by START or STOP, and that a write made under undervoltage still lands.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_ADDR,
    S_PTR,
    S_ACK_PTR,
    S_DATA,
    S_ACK_DATA,
    S_TX,
    S_MACK,
    S_IGNORE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic ackOn;
    logic relSda;
    logic loadTx;
    logic shiftTx;
    logic loadPtr;
    logic wrStb;
  } ctrlStrobe_t;

  // bus events from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclFall;
  } busEvent_t;

endpackage

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              uvloIn,
  input  ctrlStrobe_t       stb,
  output busEvent_t         ev,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sdaPullDown
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise;
  logic [BYTE_W-1:0] txShift;
  logic driveLow;

  // input synchronizers, idle bus reads high
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[LAST];
  assign sdaS = sdaSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise    = sclS & ~sclD;
  assign ev.sclFall = ~sclS & sclD;
  assign ev.startEv = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopEv  = sclS & sclD & ~sdaD & sdaS;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (sclRise) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (stb.clrCnt) bitCnt <= '0;
      else if (sclRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  // register pointer and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
    end else begin
      regWrEn <= stb.wrStb;
      if (stb.loadPtr) regAddr <= ADDR_W'(rxByte);
      if (stb.wrStb) regWrData <= rxByte;
    end
  end

  // SDA drive: acknowledge and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveLow <= 1'b0;
      txShift  <= '0;
    end else if (stb.relSda) begin
      driveLow <= 1'b0;
    end else if (stb.ackOn) begin
      driveLow <= 1'b1;
    end else if (stb.loadTx) begin
      driveLow <= ~regRdData[BYTE_W-1];
      txShift  <= {regRdData[BYTE_W-2:0], 1'b0};
    end else if (stb.shiftTx) begin
      driveLow <= ~txShift[BYTE_W-1];
      txShift  <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdaPullDown = driveLow & ~uvloIn;

  a_r8_uvlo_silent: assert property (@(posedge clk) disable iff (!rstN)
    uvloIn |-> !sdaPullDown)
    else $error("R8: SDA driven during undervoltage");

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> !sclS)
    else $error("R10: SDA pull-down started while SCL high");

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn)
    else $error("R4: write strobe longer than one cycle");

endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStrobe_t       stb
);

  busState_t state, nextState;
  logic rwBit, nextRw;
  logic addrHit, txBitSlot;

  assign addrHit   = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign txBitSlot = (bitCnt != '0) && (bitCnt < CNT_BYTE);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextRw    = rwBit;
    if (ev.stopEv) begin
      stb.relSda = 1'b1;
      stb.clrCnt = 1'b1;
      nextState  = S_IDLE;
    end else if (ev.startEv) begin
      stb.relSda = 1'b1;
      stb.clrCnt = 1'b1;
      nextState  = S_ADDR;
    end else if (ev.sclFall) begin
      unique case (state)
        S_ADDR: if (bitCnt == CNT_BYTE) begin
          if (addrHit) begin
            stb.ackOn = 1'b1;
            nextRw    = rxByte[0];
            nextState = S_ACK_ADDR;
          end else begin
            nextState = S_IGNORE;
          end
        end
        S_ACK_ADDR: if (bitCnt == CNT_ACK) begin
          stb.clrCnt = 1'b1;
          if (rwBit) begin
            stb.loadTx = 1'b1;
            nextState  = S_TX;
          end else begin
            stb.relSda = 1'b1;
            nextState  = S_PTR;
          end
        end
        S_PTR: if (bitCnt == CNT_BYTE) begin
          stb.loadPtr = 1'b1;
          stb.ackOn   = 1'b1;
          nextState   = S_ACK_PTR;
        end
        S_ACK_PTR: if (bitCnt == CNT_ACK) begin
          stb.relSda = 1'b1;
          stb.clrCnt = 1'b1;
          nextState  = S_DATA;
        end
        S_DATA: if (bitCnt == CNT_BYTE) begin
          stb.wrStb = 1'b1;
          stb.ackOn = 1'b1;
          nextState = S_ACK_DATA;
        end
        S_ACK_DATA: if (bitCnt == CNT_ACK) begin
          stb.relSda = 1'b1;
          stb.clrCnt = 1'b1;
          nextState  = S_IGNORE;
        end
        S_TX: begin
          if (txBitSlot) begin
            stb.shiftTx = 1'b1;
          end else if (bitCnt == CNT_BYTE) begin
            stb.relSda = 1'b1;
            nextState  = S_MACK;
          end
        end
        S_MACK: if (bitCnt == CNT_ACK) begin
          if (!rxByte[0]) begin
            stb.loadTx = 1'b1;
            stb.clrCnt = 1'b1;
            nextState  = S_TX;
          end else begin
            nextState = S_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      rwBit <= 1'b0;
    end else begin
      state <= nextState;
      rwBit <= nextRw;
    end
  end

  a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rstN)
    (ev.startEv && !ev.stopEv) |=> state == S_ADDR)
    else $error("R9: START did not restart address reception");

  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> state == S_IDLE)
    else $error("R9: STOP did not return to idle");

  a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (!rstN)
    state == S_IGNORE |-> !(stb.ackOn || stb.loadTx || stb.wrStb))
    else $error("R3: ignoring state touched the bus or registers");

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h60,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              uvloIn,
  output logic              sdaPullDown,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData
);

  ctrlStrobe_t       stb;
  busEvent_t         ev;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte;

  i2cRegDatapath #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .uvloIn     (uvloIn),
    .stb        (stb),
    .ev         (ev),
    .bitCnt     (bitCnt),
    .rxByte     (rxByte),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .regRdData  (regRdData),
    .sdaPullDown(sdaPullDown)
  );

  i2cRegCtrl #(
    .DEV_ADDR(DEV_ADDR)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .ev    (ev),
    .bitCnt(bitCnt),
    .rxByte(rxByte),
    .stb   (stb)
  );

endmodule

// File: tb/sim_i2cRegSlave.sv
module sim_i2cRegSlave;

  localparam logic [6:0] DEV = 7'h60;
  localparam int Q = 6;

  logic clk = 0;
  logic rstN = 0;
  logic sclM = 1, sdaM = 1, uvlo = 0;
  logic sdaPullDown, regWrEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaLine;

  logic [7:0] regFile [256];
  logic [7:0] expFile [256];
  logic [7:0] rdBuf [4];
  logic extraBit;
  int checks = 0, errors = 0, wrCount = 0, widthErr = 0, uvloViol = 0;
  logic prevWr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaPullDown;
  assign regRdData = regFile[regAddr];

  i2cRegSlave #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .uvloIn(uvlo),
    .sdaPullDown(sdaPullDown), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  // register file model and strobe monitors
  always @(posedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        regFile[regAddr] <= regWrData;
        wrCount <= wrCount + 1;
      end
      if (regWrEn && prevWr) widthErr <= widthErr + 1;
      prevWr <= regWrEn;
    end
  end

  always @(negedge clk) if (rstN && uvlo && sdaPullDown) uvloViol++;

  function automatic logic expAck(input logic [6:0] dev);
    return (dev == DEV) && !uvlo;
  endfunction

  function automatic logic [7:0] initVal(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ();
  endtask

  task automatic bitCycle(input logic b, output logic r);
    sdaM = b; waitQ(); sclM = 1; waitQ(); r = sdaLine; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitCycle(d[i], r);
    bitCycle(1'b1, r);
    ack = ~r;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, r);
      d[i] = r;
    end
    bitCycle(~mAck, r);
  endtask

  task automatic writeReg(input logic [6:0] dev, input logic [7:0] ptr, input logic [7:0] d,
                          output logic aA, output logic aP, output logic aD);
    startCond();
    sendByte({dev, 1'b0}, aA);
    sendByte(ptr, aP);
    sendByte(d, aD);
    stopCond();
  endtask

  task automatic readReg(input logic [7:0] ptr, input int n,
                         output logic aA, output logic aP, output logic aR);
    logic [7:0] d;
    startCond();
    sendByte({DEV, 1'b0}, aA);
    sendByte(ptr, aP);
    startCond();
    sendByte({DEV, 1'b1}, aR);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, d);
      rdBuf[k] = d;
    end
    bitCycle(1'b1, extraBit);
    stopCond();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic aA, aP, aD, aR, r;
    int w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      regFile[i] = initVal(i);
      expFile[i] = initVal(i);
    end
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "sdaPullDown", sdaPullDown, 0);
    chk("R1", "regWrEn", regWrEn, 0);
    chk("R1", "regAddr", regAddr, 0);

    // R2, R4: basic write
    w0 = wrCount;
    writeReg(DEV, 8'h12, 8'hA5, aA, aP, aD);
    expFile[8'h12] = 8'hA5;
    chk("R2", "address ack", aA, 1);
    chk("R4", "pointer ack", aP, 1);
    chk("R4", "data ack", aD, 1);
    chk("R4", "pointer on regAddr", regAddr, 8'h12);
    chk("R4", "write count", wrCount - w0, 1);

    // R6 read back through repeated start
    readReg(8'h12, 1, aA, aP, aR);
    chk("R6", "read address ack", aR, 1);
    chk("R6", "read data", rdBuf[0], expFile[8'h12]);

    // R3 wrong address
    w0 = wrCount;
    writeReg(7'h61, 8'h12, 8'h3C, aA, aP, aD);
    chk("R3", "acks on mismatch", {aA, aP, aD}, 3'b000);
    chk("R3", "no write", wrCount - w0, 0);
    readReg(8'h12, 1, aA, aP, aR);
    chk("R3", "register intact", rdBuf[0], 8'hA5);

    // R5 extra data byte
    w0 = wrCount;
    startCond();
    sendByte({DEV, 1'b0}, aA);
    sendByte(8'h20, aP);
    sendByte(8'h11, aD);
    chk("R5", "first data ack", aD, 1);
    sendByte(8'h22, aD);
    chk("R5", "second data not acked", aD, 0);
    stopCond();
    expFile[8'h20] = 8'h11;
    chk("R5", "single write", wrCount - w0, 1);

    // R7 repeated read with master acks, then NACK release
    readReg(8'h20, 3, aA, aP, aR);
    chk("R7", "byte0", rdBuf[0], 8'h11);
    chk("R7", "byte1 after master ack", rdBuf[1], 8'h11);
    chk("R7", "byte2 after master ack", rdBuf[2], 8'h11);
    chk("R7", "released after NACK", extraBit, 1);
    chk("R7", "pull-down idle", sdaPullDown, 0);

    // R9 STOP in the middle of a data byte
    w0 = wrCount;
    startCond();
    sendByte({DEV, 1'b0}, aA);
    sendByte(8'h30, aP);
    for (int i = 0; i < 4; i++) bitCycle(1'b0, r);
    stopCond();
    chk("R9", "no write after STOP mid-byte", wrCount - w0, 0);
    readReg(8'h30, 1, aA, aP, aR);
    chk("R9", "register intact after STOP", rdBuf[0], expFile[8'h30]);

    // R9 START in the middle of the address byte
    startCond();
    for (int i = 0; i < 3; i++) bitCycle(1'b1, r);
    startCond();
    sendByte({DEV, 1'b0}, aA);
    sendByte(8'h31, aP);
    sendByte(8'h77, aD);
    stopCond();
    expFile[8'h31] = 8'h77;
    chk("R9", "acks after restart", {aA, aP, aD}, 3'b111);
    readReg(8'h31, 1, aA, aP, aR);
    chk("R9", "write after restart", rdBuf[0], 8'h77);

    // R8 undervoltage: silent bus, decode continues
    uvlo = 1;
    w0 = wrCount;
    writeReg(DEV, 8'h40, 8'h9E, aA, aP, aD);
    expFile[8'h40] = 8'h9E;
    chk("R8", "no acks under uvlo", {aA, aP, aD}, 3'b000);
    chk("R8", "write still lands", wrCount - w0, 1);
    readReg(8'h40, 1, aA, aP, aR);
    chk("R8", "no read data under uvlo", rdBuf[0], 8'hFF);
    uvlo = 0;
    readReg(8'h40, 1, aA, aP, aR);
    chk("R8", "value after uvlo", rdBuf[0], 8'h9E);

    // random writes and reads (R2, R3, R4, R6)
    for (int it = 0; it < 16; it++) begin
      logic [6:0] dev;
      logic [7:0] ptr, d;
      logic ea;
      ptr = 8'($urandom);
      d   = 8'($urandom);
      dev = ($urandom % 4 == 0) ? (DEV ^ 7'(1 << ($urandom % 7))) : DEV;
      ea  = expAck(dev);
      writeReg(dev, ptr, d, aA, aP, aD);
      if (ea) expFile[ptr] = d;
      chk(ea ? "R2" : "R3", "random address ack", aA, ea);
      chk("R4", "random data ack", aD, ea);
      readReg(ptr, 1, aA, aP, aR);
      chk("R6", "random readback", rdBuf[0], expFile[ptr]);
    end

    chk("R8", "no drive during uvlo", uvloViol, 0);
    chk("R4", "strobe width", widthErr, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule